// File: doc/BRIEF.md
# Parallel Bus Target Controller

This block is the slave side of a 32-bit parallel bus where address and data share one set of lines. The command and byte-enable signals also share one 4-bit set of lines. All bus control lines are active low. On a falling cycle-frame edge from an idle bus, the controller captures the address and the bus command. It decides whether it is the addressed target. A memory access hits when the address falls inside a fixed, size-aligned window. A configuration access hits when the configuration chip-select input is high during the address phase. A small internal register file of 32-bit words stands behind the bus.

After a hit, the controller claims the cycle with medium timing. It paces each data phase with its target-ready output. Byte enables mask the writes. On the last word of the window, the controller raises a stop request together with target-ready, so a burst that would run past the end is disconnected with data. After the final transfer, every control output is released on the next clock. The bus interface places the block's outputs on the shared lines using the provided output-enable.

Top module: `bus_target_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `devsel_n`, `trdy_n` and `stop_n` are high and `ad_oe` is low. Every register word reads as zero after reset.
- R2: Only command codes 0110 (memory read) and 0111 (memory write) with an address inside the window, and 1010 (configuration read) and 1011 (configuration write) with `idsel` high, are claimed. For any other command or address, `devsel_n` stays high and no register changes.
- R3: `devsel_n` goes low for the first time after the second rising edge counted from the edge that samples the address phase (medium decode).
- R4: On a write, `trdy_n` falls in the same clock as `devsel_n`. On a read, `trdy_n` falls one clock later (one fixed wait state), and `ad_oe` is high from the clock `devsel_n` falls.
- R5: A data phase completes only on an edge where `irdy_n` and `trdy_n` are both low. A write stores data only on such an edge, and `trdy_n` holds low through master wait states.
- R6: Byte enable bit i low writes byte lane i (`ad_in[8i+7:8i]`, lane 0 least significant). A lane whose enable bit is high keeps its old value.
- R7: While `trdy_n` is low on a read, `ad_out` holds the word at the current index and stays stable across master wait states. The index advances by one after each completed phase.
- R8: A burst continues while `frame_n` is low at a completion. A completion with `frame_n` high is final, and on the next clock `devsel_n`, `trdy_n` and `stop_n` are high and `ad_oe` is low.
- R9: `stop_n` is low together with `trdy_n` in every data phase that addresses the last window word (index WORDS-1), and high in every other data phase.
- R10: If the last-word phase completes with `frame_n` still low, `trdy_n` goes high while `stop_n` and `devsel_n` stay low until `frame_n` is sampled high, and all are released the clock after. The index does not wrap, so no further word is written.
- R11: Memory and configuration accesses both select the word `ad_in[IDX_W+1:2]` of the same register file, where IDX_W = log2(WORDS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Address/data lines as seen by the target |
| ad_out | output | 32 | Read data driven toward the lines |
| ad_oe | output | 1 | Enable for driving `ad_out` onto the lines |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frame_n | input | 1 | Cycle frame from the master, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration chip select, sampled in the address phase |
| devsel_n | output | 1 | Device select claim, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request to the master, active low |

## Verification
The cycle properties check several rules on every clock. They check the two-clock claim delay after a decoded hit and that an ignored address phase never claims. They check that no write reaches storage without both ready lines low, and that read data holds steady across master wait states. They also check the one-clock release after a final phase, the backoff hold after a disconnect, and the one-step index advance. Only the bench scenarios can show the stored contents: byte-lane masking, configuration and memory accesses reaching the same word, and that ignored commands leave storage untouched. The same applies to the exact clock in which stop appears on the last word of a burst, and to the truncated length of a burst that runs past the window end.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_RWAIT,
    ST_XFER,
    ST_BACKOFF
  } bt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
endpackage

// File: rtl/bt_decode.sv
module bt_decode
  import bt_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          IDX_W     = 3,
  parameter logic [31:0] BASE_ADDR = 32'h0000_2000
) (
  input  logic [ADDR_W-1:0] ad,
  input  logic [3:0]        cmd,
  input  logic              sel,
  output logic              hit,
  output logic              is_rd,
  output logic [IDX_W-1:0]  idx
);
  localparam int TAG_LO = IDX_W + 2;

  logic mem_cmd;
  logic cfg_cmd;
  logic in_win;

  always_comb begin
    mem_cmd = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    cfg_cmd = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
    in_win  = (ad[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO]);
    hit     = (mem_cmd && in_win) || (cfg_cmd && sel);
    // bit 0 of every decoded command separates read (0) from write (1)
    is_rd   = !cmd[0];
    idx     = ad[TAG_LO-1:2];
  end
endmodule

// File: rtl/bt_regfile.sv
module bt_regfile #(
  parameter int WORDS  = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] be_n,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] word_arr [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              word_en;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;

    always_comb begin
      word_en = we && (idx == IDX_W'(w));
      word_d  = word_q;
      for (int l = 0; l < LANES; l++) begin
        if (!be_n[l]) word_d[8*l +: 8] = wdata[8*l +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign word_arr[w] = word_q;
  end

  assign rdata = word_arr[idx];
endmodule

// File: rtl/bt_fsm.sv
module bt_fsm
  import bt_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             addr_hit,
  input  logic             addr_rd,
  input  logic [IDX_W-1:0] addr_idx,
  output logic             addr_phase,
  output logic             devsel_act,
  output logic             trdy_act,
  output logic             stop_act,
  output logic             oe_act,
  output logic             wr_en,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  bt_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rd_q, rd_d;
  logic             frame_q;
  logic             last_word;
  logic             done;
  logic             ctx_en;

  always_comb begin
    addr_phase = (state_q == ST_IDLE) && !frame_n && frame_q;
    last_word  = (idx_q == LAST_IDX);
    done       = (state_q == ST_XFER) && !irdy_n;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rd_d    = rd_q;
    ctx_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (addr_phase && addr_hit) begin
          state_d = ST_CLAIM;
          idx_d   = addr_idx;
          rd_d    = addr_rd;
          ctx_en  = 1'b1;
        end
      end
      ST_CLAIM:  state_d = rd_q ? ST_RWAIT : ST_XFER;
      ST_RWAIT:  state_d = ST_XFER;
      ST_XFER: begin
        if (done) begin
          if (frame_n) begin
            state_d = ST_IDLE;
          end else if (last_word) begin
            state_d = ST_BACKOFF;
          end else begin
            idx_d  = idx_q + 1'b1;
            ctx_en = 1'b1;
          end
        end
      end
      ST_BACKOFF: if (frame_n) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b1;
    end else begin
      state_q <= state_d;
      frame_q <= frame_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rd_q  <= 1'b0;
    end else if (ctx_en) begin
      idx_q <= idx_d;
      rd_q  <= rd_d;
    end
  end

  // output decode
  always_comb begin
    devsel_act = (state_q == ST_RWAIT) || (state_q == ST_XFER) || (state_q == ST_BACKOFF);
    trdy_act   = (state_q == ST_XFER);
    stop_act   = ((state_q == ST_XFER) && last_word) || (state_q == ST_BACKOFF);
    oe_act     = rd_q && ((state_q == ST_RWAIT) || (state_q == ST_XFER));
    wr_en      = done && !rd_q;
    cur_idx    = idx_q;
  end

  // R7: a completed non-final phase below the last word steps the index by one
  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frame_n && !last_word) |=> (idx_q == $past(idx_q) + 1'b1));

  // R10: after a disconnect the block stays in backoff while the frame is held
  p_backoff_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_BACKOFF) && !frame_n) |=> (state_q == ST_BACKOFF));
endmodule

// File: rtl/bus_target_ctrl.sv
module bus_target_ctrl #(
  parameter int          WORDS     = 8,
  parameter logic [31:0] BASE_ADDR = 32'h0000_2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  input  logic [3:0]  cbe_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n
);
  localparam int ADDR_W = 32;
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic             addr_hit;
  logic             addr_rd;
  logic [IDX_W-1:0] addr_idx;
  logic             addr_phase;
  logic             devsel_act;
  logic             trdy_act;
  logic             stop_act;
  logic             oe_act;
  logic             wr_en;
  logic [IDX_W-1:0] cur_idx;
  logic [31:0]      rdata;

  bt_decode #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .ad    (ad_in),
    .cmd   (cbe_n),
    .sel   (idsel),
    .hit   (addr_hit),
    .is_rd (addr_rd),
    .idx   (addr_idx)
  );

  bt_fsm #(
    .WORDS (WORDS),
    .IDX_W (IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .addr_hit   (addr_hit),
    .addr_rd    (addr_rd),
    .addr_idx   (addr_idx),
    .addr_phase (addr_phase),
    .devsel_act (devsel_act),
    .trdy_act   (trdy_act),
    .stop_act   (stop_act),
    .oe_act     (oe_act),
    .wr_en      (wr_en),
    .cur_idx    (cur_idx)
  );

  bt_regfile #(
    .WORDS  (WORDS),
    .IDX_W  (IDX_W),
    .DATA_W (32)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .idx   (cur_idx),
    .wdata (ad_in),
    .be_n  (cbe_n),
    .rdata (rdata)
  );

  assign devsel_n = !devsel_act;
  assign trdy_n   = !trdy_act;
  assign stop_n   = !stop_act;
  assign ad_oe    = oe_act;
  assign ad_out   = oe_act ? rdata : '0;

  // R2: an address phase that does not decode leaves the claim released
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !addr_hit) |=> devsel_n);

  // R3: a claim appears exactly two edges after a decoded address phase
  p_claim_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(addr_phase && addr_hit, 2));

  // R4: the lines are only driven while the cycle is claimed
  p_oe_claimed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !devsel_n);

  // R5: storage is written only when both ready lines are low
  p_write_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!irdy_n && !trdy_n));

  // R7: read data and target-ready hold through master wait states
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n && ad_oe) |=> (!trdy_n && $stable(ad_out)));

  // R8: a final completion releases every control output on the next clock
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n && !ad_oe));

  // R10: disconnect with data keeps stop and claim while dropping target-ready
  p_disconnect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && !stop_n && !frame_n) |=> (trdy_n && !stop_n && !devsel_n));
endmodule

// File: tb/tb_bus_target_ctrl.sv
`timescale 1ns/1ps
module tb_bus_target_ctrl;
  logic        clk;
  logic        rst_n;
  logic [31:0] ad_in;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [3:0]  cbe_n;
  logic        frame_n;
  logic        irdy_n;
  logic        idsel;
  logic        devsel_n;
  logic        trdy_n;
  logic        stop_n;

  bus_target_ctrl #(.WORDS(8), .BASE_ADDR(32'h0000_2000)) dut (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic [31:0] wd_v [8];
  logic [3:0]  be_v [8];
  int          wt_v [8];
  logic [31:0] rd_v [8];
  bit          st_v [8];
  int          dev_at, trdy_at, done_ph;
  bit          rel_ok, bo_ok;

  // {cmd, addr, idsel, data, be_n, claimed, expected read data}
  localparam int NV = 14;
  localparam logic [105:0] VEC [NV] = '{
    {4'b0111, 32'h0000_2000, 1'b0, 32'hA5A5_1234, 4'b0000, 1'b1, 32'h0000_0000},
    {4'b0110, 32'h0000_2000, 1'b0, 32'h0000_0000, 4'b0000, 1'b1, 32'hA5A5_1234},
    {4'b0111, 32'h0000_2004, 1'b0, 32'hDEAD_BEEF, 4'b1010, 1'b1, 32'h0000_0000},
    {4'b0110, 32'h0000_2004, 1'b0, 32'h0000_0000, 4'b0000, 1'b1, 32'h00AD_00EF},
    {4'b1011, 32'h0000_0008, 1'b1, 32'h1122_3344, 4'b0000, 1'b1, 32'h0000_0000},
    {4'b0110, 32'h0000_2008, 1'b0, 32'h0000_0000, 4'b0000, 1'b1, 32'h1122_3344},
    {4'b1011, 32'h0000_000C, 1'b0, 32'hFFFF_FFFF, 4'b0000, 1'b0, 32'h0000_0000},
    {4'b1010, 32'h0000_000C, 1'b1, 32'h0000_0000, 4'b0000, 1'b1, 32'h0000_0000},
    {4'b0011, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF, 4'b0000, 1'b0, 32'h0000_0000},
    {4'b0110, 32'h0000_2000, 1'b0, 32'h0000_0000, 4'b0000, 1'b1, 32'hA5A5_1234},
    {4'b0111, 32'h0000_3000, 1'b0, 32'hFFFF_FFFF, 4'b0000, 1'b0, 32'h0000_0000},
    {4'b0110, 32'h0000_1FFC, 1'b0, 32'h0000_0000, 4'b0000, 1'b0, 32'h0000_0000},
    {4'b0111, 32'h0000_2008, 1'b0, 32'h9900_0000, 4'b0111, 1'b1, 32'h0000_0000},
    {4'b1010, 32'h0000_0008, 1'b1, 32'h0000_0000, 4'b0000, 1'b1, 32'h9922_3344}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                         input int nph, input int lim);
    int  cyc;
    int  ph;
    int  wcnt;
    bit  stopped;
    bit  adv;
    dev_at = -1; trdy_at = -1; stopped = 0; ph = 0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; idsel = sel;
    @(negedge clk);
    cyc = 1; idsel = 1'b0;
    ad_in = wd_v[0]; cbe_n = be_v[0]; frame_n = (nph == 1); wcnt = wt_v[0]; irdy_n = (wcnt != 0);
    while (ph < nph && !stopped && cyc < lim) begin
      adv = 0;
      if (!devsel_n && dev_at < 0) dev_at = cyc;
      if (!trdy_n && trdy_at < 0) trdy_at = cyc;
      if (!trdy_n && !irdy_n) begin
        rd_v[ph] = ad_out; st_v[ph] = !stop_n; ph++; adv = 1;
        if (!stop_n && ph < nph) stopped = 1;
      end
      @(negedge clk); cyc++;
      if (stopped || ph >= nph) begin
        frame_n = 1'b1; irdy_n = 1'b1;
      end else if (adv) begin
        ad_in = wd_v[ph]; cbe_n = be_v[ph]; frame_n = (ph == nph - 1);
        wcnt = wt_v[ph]; irdy_n = (wcnt != 0);
      end else if (wcnt > 0) begin
        wcnt--; irdy_n = (wcnt != 0);
      end
    end
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    done_ph = ph;
    if (stopped) begin
      bo_ok = !stop_n && trdy_n && !devsel_n;
      @(negedge clk);
    end else begin
      bo_ok = 1;
    end
    rel_ok = devsel_n && trdy_n && stop_n && !ad_oe;
  endtask

  task automatic clear_phases();
    for (int i = 0; i < 8; i++) begin
      wd_v[i] = '0; be_v[i] = 4'h0; wt_v[i] = 0; rd_v[i] = '0; st_v[i] = 0;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ad_in = '0; cbe_n = 4'hF; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0;
    clear_phases();
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !ad_oe, "R1 outputs idle in reset",
        {28'h0, devsel_n, trdy_n, stop_n, ad_oe}, 32'he);
    rst_n = 1'b1;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !ad_oe, "R1 outputs idle after reset",
        {28'h0, devsel_n, trdy_n, stop_n, ad_oe}, 32'he);
    clear_phases();
    run_txn(4'b0110, 32'h0000_201C, 1'b0, 1, 12);
    chk(rd_v[0] == 32'h0, "R1 register word reads zero after reset", rd_v[0], 32'h0);

    // table of single-phase accesses
    for (int v = 0; v < NV; v++) begin
      logic [105:0] e;
      logic [3:0]   c;
      bit           rd;
      e  = VEC[v];
      c  = e[105:102];
      rd = !c[0];
      clear_phases();
      wd_v[0] = e[68:37]; be_v[0] = e[36:33];
      run_txn(c, e[101:70], e[69], 1, 10);
      if (e[32]) begin
        chk(dev_at == 2, $sformatf("R3 claim timing vec %0d", v), dev_at, 2);
        chk(trdy_at == (rd ? 3 : 2), $sformatf("R4 ready timing vec %0d", v), trdy_at, rd ? 3 : 2);
        chk(done_ph == 1, $sformatf("R5 phase completed vec %0d", v), done_ph, 1);
        if (rd)
          chk(rd_v[0] == e[31:0], $sformatf("R6 R11 read data vec %0d", v), rd_v[0], e[31:0]);
      end else begin
        chk(dev_at == -1, $sformatf("R2 not claimed vec %0d", v), dev_at, -1);
      end
      chk(rel_ok, $sformatf("R8 released vec %0d", v), rel_ok, 1);
    end

    // burst write to words 4..7 with master waits in phase 1; stop only on word 7
    clear_phases();
    for (int i = 0; i < 4; i++) wd_v[i] = 32'hB000_0000 + i;
    wt_v[1] = 2;
    run_txn(4'b0111, 32'h0000_2010, 1'b0, 4, 30);
    chk(done_ph == 4, "R8 burst write length", done_ph, 4);
    chk(st_v[0] == 0 && st_v[1] == 0 && st_v[2] == 0, "R9 no stop before last word",
        {st_v[0], st_v[1], st_v[2]}, 0);
    chk(st_v[3] == 1, "R9 stop with ready on last word", st_v[3], 1);
    chk(rel_ok, "R8 burst write release", rel_ok, 1);

    // burst read back with a wait in phase 2
    clear_phases();
    wt_v[2] = 1;
    run_txn(4'b0110, 32'h0000_2010, 1'b0, 4, 30);
    for (int i = 0; i < 4; i++)
      chk(rd_v[i] == 32'hB000_0000 + i, $sformatf("R7 R5 burst read word %0d", i),
          rd_v[i], 32'hB000_0000 + i);
    chk(st_v[3] == 1 && st_v[2] == 0, "R9 read stop on last word", {st_v[2], st_v[3]}, 1);

    // burst crossing the window end: disconnect with data after word 7
    clear_phases();
    for (int i = 0; i < 4; i++) wd_v[i] = 32'hC000_0000 + i;
    run_txn(4'b0111, 32'h0000_2018, 1'b0, 4, 30);
    chk(done_ph == 2, "R10 burst truncated at window end", done_ph, 2);
    chk(st_v[1] == 1 && st_v[0] == 0, "R9 stop on crossing phase", {st_v[0], st_v[1]}, 1);
    chk(bo_ok, "R10 backoff holds stop and claim", bo_ok, 1);
    chk(rel_ok, "R10 release after frame high", rel_ok, 1);
    clear_phases();
    run_txn(4'b0110, 32'h0000_2018, 1'b0, 2, 20);
    chk(rd_v[0] == 32'hC000_0000 && rd_v[1] == 32'hC000_0001, "R10 words 6 and 7 written",
        rd_v[1], 32'hC000_0001);
    clear_phases();
    run_txn(4'b0110, 32'h0000_2000, 1'b0, 1, 10);
    chk(rd_v[0] == 32'hA5A5_1234, "R10 no wrap into word 0", rd_v[0], 32'hA5A5_1234);

    // reset clears storage again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    clear_phases();
    run_txn(4'b0110, 32'h0000_2000, 1'b0, 1, 10);
    chk(rd_v[0] == 32'h0, "R1 storage cleared by reset", rd_v[0], 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule